// File: doc/BRIEF.md
# Funnel Shifter with Lane Swap and Shuffle

This is a combinational shift, rotate and permute unit for an ALU datapath. The operand is placed into a funnel twice its own width. The two halves of the funnel are filled according to the operation. A window as wide as the operand is then taken from the funnel at an offset set by the shift amount. Any shift or rotate distance therefore resolves in the same pass, with no cycle-by-cycle stepping.

The same unit also applies two fixed byte-lane permutations. The first exchanges the upper and lower halves of the word. The second interleaves the lanes of the lower half with the lanes of the upper half. The output is a pure function of the data, amount and operation inputs, so a register stage can be placed on either side as the surrounding pipeline needs.

Top module: `funnel_shifter`

## Requirements
- R1: Operation code 3'b000 is a logical right shift. The result equals the operand shifted toward bit 0 by `amt_i` places, with zeros entering at the most significant end.
- R2: Operation code 3'b001 is a logical left shift. The result equals the operand shifted toward the MSB by `amt_i` places, with zeros entering at bit 0.
- R3: Operation code 3'b010 rotates right by `amt_i` places. Bits leaving at bit 0 re-enter at the MSB, so the count of set bits is preserved.
- R4: In each of the three shift and rotate operations, exactly one window position of the funnel is selected.
- R5: When `amt_i` is zero, each of the three shift and rotate operations returns the operand unchanged.
- R6: Operation code 3'b011 exchanges the two halfwords. For a 32-bit word with bytes B3..B0 (B0 at bits 7:0), the result holds B1,B0 in the upper half and B3,B2 in the lower half. `amt_i` has no effect.
- R7: Operation code 3'b100 interleaves the byte lanes. Output lane 2j takes input lane j, and output lane 2j+1 takes input lane j+L/2, where L is the lane count. For 32 bits, the result bytes from bit 0 upward are B0,B2,B1,B3. `amt_i` has no effect.
- R8: Operation codes 3'b101, 3'b110 and 3'b111 return the operand unchanged, whatever the value of `amt_i`.
- R9: The result depends only on the current inputs and settles with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | WIDTH | Operand |
| amt_i | input | $clog2(WIDTH) | Shift or rotate distance |
| op_i | input | 3 | Operation code |
| result_o | output | WIDTH | Shifted, rotated or permuted word |

## Verification
The embedded assertions are evaluated on every input change. They cover the following:
- the window select is one-hot in the shift modes and empty in the other modes;
- a zero amount and the unused codes pass the operand through;
- a rotate preserves the set-bit count;
- a shift with a nonzero amount empties the bit at the end that zeros enter from;
- each permutation preserves the set-bit count.

The exact bit placement of every mode, checked across every amount, can only be shown by the bench's scenarios against its behavioural reference. The same holds for the specific lane orders of the swap and the shuffle, and for the boundary amounts one and WIDTH-1.

// File: rtl/funnel_shifter.sv
module funnel_shifter #(
  parameter int WIDTH = 32,
  parameter int LANE  = 8
) (
  input  logic [WIDTH-1:0]         data_i,
  input  logic [$clog2(WIDTH)-1:0] amt_i,
  input  logic [2:0]               op_i,
  output logic [WIDTH-1:0]         result_o
);
  localparam int SHW   = $clog2(WIDTH);
  localparam int NLANE = WIDTH / LANE;
  localparam int HALF  = WIDTH / 2;

  localparam logic [2:0] OP_SRL  = 3'b000;
  localparam logic [2:0] OP_SLL  = 3'b001;
  localparam logic [2:0] OP_ROR  = 3'b010;
  localparam logic [2:0] OP_SWAP = 3'b011;
  localparam logic [2:0] OP_SHUF = 3'b100;

  logic               is_shift;
  logic [2*WIDTH-1:0] funnel;
  logic [SHW:0]       offset;
  logic [WIDTH:0]     sel;
  logic [WIDTH-1:0]   part [WIDTH+1];
  logic [WIDTH-1:0]   windowed;
  logic [WIDTH-1:0]   swapped;
  logic [WIDTH-1:0]   shuffled;

  assign is_shift = (op_i == OP_SRL) || (op_i == OP_SLL) || (op_i == OP_ROR);

  always_comb begin
    case (op_i)
      OP_SLL:  funnel = {data_i, {WIDTH{1'b0}}};
      OP_ROR:  funnel = {data_i, data_i};
      default: funnel = {{WIDTH{1'b0}}, data_i};
    endcase
  end

  assign offset = (op_i == OP_SLL) ? ((SHW+1)'(WIDTH) - {1'b0, amt_i}) : {1'b0, amt_i};

  for (genvar i = 0; i <= WIDTH; i++) begin : g_window
    assign sel[i]  = is_shift && (offset == (SHW+1)'(i));
    assign part[i] = sel[i] ? funnel[i +: WIDTH] : '0;
  end

  always_comb begin
    windowed = '0;
    for (int i = 0; i <= WIDTH; i++) windowed = windowed | part[i];
  end

  assign swapped = {data_i[HALF-1:0], data_i[WIDTH-1:HALF]};

  for (genvar j = 0; j < NLANE/2; j++) begin : g_shuffle
    assign shuffled[(2*j)*LANE   +: LANE] = data_i[j*LANE           +: LANE];
    assign shuffled[(2*j+1)*LANE +: LANE] = data_i[(j+NLANE/2)*LANE +: LANE];
  end

  always_comb begin
    case (op_i)
      OP_SRL, OP_SLL, OP_ROR: result_o = windowed;
      OP_SWAP:                result_o = swapped;
      OP_SHUF:                result_o = shuffled;
      default:                result_o = data_i;
    endcase
  end

  always_comb begin
    if (is_shift)
      p_onehot_window_r4: assert ($countones(sel) == 1);
    else
      p_no_window_r4: assert (sel == '0);
    if (is_shift && amt_i == '0)
      p_zero_amount_r5: assert (result_o == data_i);
    if (op_i > OP_SHUF)
      p_unused_pass_r8: assert (result_o == data_i);
    if (op_i == OP_ROR)
      p_rotate_keeps_ones_r3: assert ($countones(result_o) == $countones(data_i));
    if (op_i == OP_SRL && amt_i != '0)
      p_srl_msb_clear_r1: assert (result_o[WIDTH-1] == 1'b0);
    if (op_i == OP_SLL && amt_i != '0)
      p_sll_lsb_clear_r2: assert (result_o[0] == 1'b0);
    if (op_i == OP_SWAP)
      p_swap_keeps_ones_r6: assert ($countones(result_o) == $countones(data_i));
    if (op_i == OP_SHUF)
      p_shuf_keeps_ones_r7: assert ($countones(result_o) == $countones(data_i));
  end
endmodule

// File: tb/funnel_shifter_tb.sv
module funnel_shifter_tb;
  localparam int W = 32;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  data;
  logic [4:0]    amt;
  logic [2:0]    op;
  logic [W-1:0]  res;
  int            n_checks = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  funnel_shifter #(.WIDTH(W), .LANE(8)) u_dut (
    .data_i(data), .amt_i(amt), .op_i(op), .result_o(res)
  );

  localparam logic [2:0]   V_OP  [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5,
                                          3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd7};
  localparam logic [4:0]   V_AMT [NV] = '{5'd4, 5'd8, 5'd4, 5'd0, 5'd0, 5'd9,
                                          5'd31, 5'd31, 5'd1, 5'd17, 5'd5, 5'd0};
  localparam logic [W-1:0] V_DAT [NV] = '{32'h12345678, 32'h12345678, 32'h12345678,
                                          32'h12345678, 32'h12345678, 32'h12345678,
                                          32'h80000000, 32'h00000001, 32'h00000001,
                                          32'hAABBCCDD, 32'hAABBCCDD, 32'hCAFEF00D};
  localparam logic [W-1:0] V_EXP [NV] = '{32'h01234567, 32'h34567800, 32'h81234567,
                                          32'h56781234, 32'h12563478, 32'h12345678,
                                          32'h00000001, 32'h80000000, 32'h80000000,
                                          32'hCCDDAABB, 32'hAACCBBDD, 32'hCAFEF00D};
  localparam string        V_REQ [NV] = '{"R1", "R2", "R3", "R6", "R7", "R8",
                                          "R1", "R2", "R3", "R6", "R7", "R8"};

  task automatic apply(input logic [2:0] o, input logic [4:0] a, input logic [W-1:0] d);
    @(negedge clk);
    op = o; amt = a; data = d;
    #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] exp);
    n_checks++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d amt=%0d data=%h actual=%h expected=%h",
               req, op, amt, data, res, exp);
    end
  endtask

  function automatic logic [W-1:0] ror(input logic [W-1:0] d, input int k);
    return (d >> k) | (d << (W - k));
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    op = 3'd0; amt = '0; data = '0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // R9: a zero operand yields zero, settled without any clock edge
    for (int o = 0; o < 8; o++) begin
      apply(3'(o), 5'd7, '0);
      check("R9", '0);
    end
    for (int v = 0; v < NV; v++) begin
      apply(V_OP[v], V_AMT[v], V_DAT[v]);
      check(V_REQ[v], V_EXP[v]);
    end
    for (int t = 0; t < 3; t++) begin
      logic [W-1:0] d;
      d = (t == 0) ? 32'hDEADBEEF : (t == 1) ? 32'h80000001 : 32'h0F0F3C3C;
      for (int k = 0; k < W; k++) begin
        apply(3'd0, 5'(k), d); check("R1", d >> k);
        apply(3'd1, 5'(k), d); check("R2", d << k);
        apply(3'd2, 5'(k), d); check("R3", ror(d, k));
      end
      // R5: zero amount leaves the operand intact in every shift mode
      for (int o = 0; o < 3; o++) begin
        apply(3'(o), 5'd0, d); check("R5", d);
      end
      // R4: a single selected window gives an exact one-bit move at the boundary amount
      apply(3'd2, 5'd31, d); check("R4", {d[30:0], d[31]});
      // R6 and R7: the amount input has no effect on the permutations
      apply(3'd3, 5'd13, d); check("R6", {d[15:0], d[31:16]});
      apply(3'd4, 5'd26, d); check("R7", {d[31:24], d[15:8], d[23:16], d[7:0]});
      apply(3'd6, 5'd3, d);  check("R8", d);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule